// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block keeps a small set of recent virtual-to-physical page translations so that most memory accesses skip the page table. Every entry is searched at once. A lookup matches when both the 20-bit virtual page number and the 8-bit address-space identifier agree. The identifier is taken from a register that software writes. On a match the block returns, in the same cycle, the physical page number, the read/write/execute permission bits, the dirty bit and the slot that matched.

On a miss the block raises a walk request to an external page table walker. The request carries the page number and the current identifier. The walker answers with a fill. A fill either installs a translation or reports a page fault. A fault passes straight to the requester, and nothing is stored. Entries from different address spaces can sit side by side, so a context switch does not require a flush. Software can still drop every entry, or only the entries of one identifier.

A fill picks its slot in this order. First comes an existing entry with the same page and identifier. Next comes the lowest-numbered free slot. Last comes a round-robin victim.

Top module: `tlb_fa_asid`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: A lookup that matches a valid entry on both page number and current identifier sets `lk_hit` in the same cycle and returns that entry's `lk_ppn`, `lk_perm` (bit 2 read, bit 1 write, bit 0 execute), `lk_dirty` and its slot number on `lk_slot`.
- R3: An entry whose stored identifier differs from the current one never hits. Entries with the same page number and different identifiers coexist in separate slots.
- R4: A lookup that misses raises `walk_req` in the same cycle, with `walk_vpn` equal to the looked-up page and `walk_asid` equal to the current identifier.
- R5: A fill with `fill_fault` set raises `req_fault` in the same cycle, installs nothing and evicts nothing.
- R6: When no entry matches the fill's page and identifier and a slot is free, the fill goes to the lowest-numbered free slot.
- R7: When all slots are valid, a fill with no matching entry evicts the slot named by a round-robin pointer. The pointer is 0 after reset, advances by one on each eviction, and wraps from the last slot to slot 0.
- R8: A fill whose page and identifier equal those of a valid entry overwrites that entry in place, and it does not move the round-robin pointer.
- R9: `flush_all` clears every valid bit at the next clock edge.
- R10: `flush_asid_en` clears, at the next clock edge, only the entries whose identifier equals `flush_asid`.
- R11: A fill in the same cycle as either flush command is dropped.
- R12: A write to the current-identifier register takes effect for lookups from the next cycle. A lookup in the same cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_we | input | 1 | Write enable for the current-identifier register |
| asid_wdata | input | 8 | New current identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_slot | output | $clog2(ENTRIES) | Index of the matching slot |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_perm | output | 3 | Permissions of the hit (read, write, execute) |
| lk_dirty | output | 1 | Dirty bit of the hit |
| walk_req | output | 1 | Miss: request to the page table walker |
| walk_vpn | output | 20 | Page number for the walker |
| walk_asid | output | 8 | Identifier for the walker |
| fill_valid | input | 1 | Walker response present |
| fill_fault | input | 1 | Walker response is a page fault |
| fill_vpn | input | 20 | Page number of the response |
| fill_asid | input | 8 | Identifier of the response |
| fill_ppn | input | 20 | Physical page number of the response |
| fill_perm | input | 3 | Permissions of the response |
| fill_dirty | input | 1 | Dirty bit of the response |
| req_fault | output | 1 | Fault passed to the requester |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |

## Verification
The assertions assume that at most one entry matches any page-and-identifier pair. That holds only because every fill checks for a duplicate tag first. They also assume that `fill_valid` is a one-cycle pulse for each walker response, and that reset is held from time zero for several edges. The bench keeps to this. It drives each fill for exactly one clock, gives every fill a page and identifier pair that is either new or deliberately repeated, and changes inputs only on the falling edge. Because lookups are combinational, a lookup never overlaps a fill in the same cycle, except in the one identifier-write case it checks on purpose.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VPN_W  = 20;
  parameter int PPN_W  = 20;
  parameter int ASID_W = 8;
  parameter int PERM_W = 3;

  typedef logic [VPN_W-1:0]  vpn_t;
  typedef logic [PPN_W-1:0]  ppn_t;
  typedef logic [ASID_W-1:0] asid_t;
  typedef logic [PERM_W-1:0] perm_t;

  typedef struct packed {
    vpn_t  vpn;
    asid_t asid;
    ppn_t  ppn;
    perm_t perm;
    logic  dirty;
  } tlb_entry_t;

  localparam int ENTRY_W = $bits(tlb_entry_t);

  // tag comparison shared by lookup and fill-duplicate probing
  function automatic logic tag_eq(input tlb_entry_t e, input vpn_t v, input asid_t a);
    return (e.vpn == v) && (e.asid == a);
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vpn_t               look_vpn,
  input  asid_t              look_asid,
  input  vpn_t               probe_vpn,
  input  asid_t              probe_asid,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  tlb_entry_t         wr_entry,
  input  logic               flush_all,
  input  logic               flush_sel,
  input  asid_t              flush_asid,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] look_match,
  output logic [ENTRIES-1:0] probe_match,
  output logic [IDX_W-1:0]   look_slot,
  output tlb_entry_t         look_entry
);
  tlb_entry_t         ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] flush_hit;

  assign valid_vec = valid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_match[g]  = valid_q[g] && tag_eq(ent_q[g], look_vpn, look_asid);
    assign probe_match[g] = valid_q[g] && tag_eq(ent_q[g], probe_vpn, probe_asid);
    assign flush_hit[g]   = flush_sel && (ent_q[g].asid == flush_asid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_hit[i])
          valid_q[i] <= 1'b0;
        else if (wr_en && (wr_idx == IDX_W'(i)))
          valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_entry;
    end
  end

  // at most one slot matches, so an OR-reduction acts as the read mux
  always_comb begin
    logic [ENTRY_W-1:0] acc;
    acc       = '0;
    look_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_match[i]) begin
        acc       = acc | ent_q[i];
        look_slot = look_slot | IDX_W'(i);
      end
    end
    look_entry = tlb_entry_t'(acc);
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               evict_ev,
  output logic [IDX_W-1:0]   rr_ptr
);
  function automatic logic [IDX_W-1:0] first_free(input logic [ENTRIES-1:0] v);
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!v[i]) first_free = IDX_W'(i);
  endfunction

  function automatic logic [IDX_W-1:0] onehot_index(input logic [ENTRIES-1:0] v);
    onehot_index = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (v[i]) onehot_index = onehot_index | IDX_W'(i);
  endfunction

  function automatic logic [IDX_W-1:0] rr_step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  logic             all_valid;
  logic             dup_any;
  logic [IDX_W-1:0] rr_q;

  assign all_valid = &valid_vec;
  assign dup_any   = |dup_vec;
  assign evict_ev  = fill_go && all_valid && !dup_any;
  assign rr_ptr    = rr_q;

  always_comb begin
    if (dup_any)         victim_idx = onehot_index(dup_vec);
    else if (!all_valid) victim_idx = first_free(valid_vec);
    else                 victim_idx = rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rr_q <= '0;
    else if (evict_ev) rr_q <= rr_step(rr_q);
  end
endmodule

// File: rtl/tlb_fa_asid.sv
module tlb_fa_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             asid_we,
  input  logic [7:0]       asid_wdata,
  input  logic             lk_valid,
  input  logic [19:0]      lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_slot,
  output logic [19:0]      lk_ppn,
  output logic [2:0]       lk_perm,
  output logic             lk_dirty,
  output logic             walk_req,
  output logic [19:0]      walk_vpn,
  output logic [7:0]       walk_asid,
  input  logic             fill_valid,
  input  logic             fill_fault,
  input  logic [19:0]      fill_vpn,
  input  logic [7:0]       fill_asid,
  input  logic [19:0]      fill_ppn,
  input  logic [2:0]       fill_perm,
  input  logic             fill_dirty,
  output logic             req_fault,
  input  logic             flush_all,
  input  logic             flush_asid_en,
  input  logic [7:0]       flush_asid
);
  asid_t              cur_asid;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic [IDX_W-1:0]   hit_slot;
  tlb_entry_t         hit_entry;
  tlb_entry_t         new_entry;
  logic               any_match;
  logic               fill_go;
  logic [IDX_W-1:0]   victim_idx;
  logic               evict_ev;
  logic [IDX_W-1:0]   rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_asid <= '0;
    else if (asid_we) cur_asid <= asid_wdata;
  end

  assign fill_go   = fill_valid && !fill_fault && !flush_all && !flush_asid_en;
  assign req_fault = fill_valid && fill_fault;
  assign new_entry = '{vpn: fill_vpn, asid: fill_asid, ppn: fill_ppn,
                       perm: fill_perm, dirty: fill_dirty};

  tlb_entry_store #(.ENTRIES(ENTRIES)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vpn   (lk_vpn),
    .look_asid  (cur_asid),
    .probe_vpn  (fill_vpn),
    .probe_asid (fill_asid),
    .wr_en      (fill_go),
    .wr_idx     (victim_idx),
    .wr_entry   (new_entry),
    .flush_all  (flush_all),
    .flush_sel  (flush_asid_en),
    .flush_asid (flush_asid),
    .valid_vec  (valid_vec),
    .look_match (match_vec),
    .probe_match(dup_vec),
    .look_slot  (hit_slot),
    .look_entry (hit_entry)
  );

  tlb_victim_pick #(.ENTRIES(ENTRIES)) pick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .dup_vec   (dup_vec),
    .fill_go   (fill_go),
    .victim_idx(victim_idx),
    .evict_ev  (evict_ev),
    .rr_ptr    (rr_ptr)
  );

  assign any_match = |match_vec;
  assign lk_hit    = lk_valid && any_match;
  assign lk_slot   = lk_hit ? hit_slot       : '0;
  assign lk_ppn    = lk_hit ? hit_entry.ppn  : '0;
  assign lk_perm   = lk_hit ? hit_entry.perm : '0;
  assign lk_dirty  = lk_hit && hit_entry.dirty;
  assign walk_req  = lk_valid && !any_match;
  assign walk_vpn  = lk_vpn;
  assign walk_asid = cur_asid;
endmodule

// File: rtl/tlb_fa_asid_chk.sv
module tlb_fa_asid_chk #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec,
  input logic               fill_go,
  input logic               fill_valid,
  input logic               fill_fault,
  input logic               flush_all,
  input logic               flush_asid_en,
  input logic [IDX_W-1:0]   victim_idx,
  input logic               evict_ev,
  input logic [IDX_W-1:0]   rr_ptr
);
  logic just_out_of_reset;
  always_ff @(posedge clk) just_out_of_reset <= !rst_n;

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    just_out_of_reset |-> (valid_vec == '0));

  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r5_fault_installs_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_fault && !flush_all && !flush_asid_en) |=> (valid_vec == $past(valid_vec)));

  a_r6_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !flush_all) |=> valid_vec[$past(victim_idx)]);

  a_r7_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ev |=> (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? IDX_W'(0) : IDX_W'($past(rr_ptr) + 1'b1))));

  a_r8_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_ev |=> $stable(rr_ptr));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  a_r11_flush_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !fill_go);
endmodule

bind tlb_fa_asid tlb_fa_asid_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid_vec    (valid_vec),
  .match_vec    (match_vec),
  .fill_go      (fill_go),
  .fill_valid   (fill_valid),
  .fill_fault   (fill_fault),
  .flush_all    (flush_all),
  .flush_asid_en(flush_asid_en),
  .victim_idx   (victim_idx),
  .evict_ev     (evict_ev),
  .rr_ptr       (rr_ptr)
);

// File: tb/tlb_fa_asid_tb_top.sv
`timescale 1ns/1ps
module tlb_fa_asid_tb_top;
  localparam int ENTRIES = 32;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             asid_we = 1'b0;
  logic [7:0]       asid_wdata = '0;
  logic             lk_valid = 1'b0;
  logic [19:0]      lk_vpn = '0;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_slot;
  logic [19:0]      lk_ppn;
  logic [2:0]       lk_perm;
  logic             lk_dirty;
  logic             walk_req;
  logic [19:0]      walk_vpn;
  logic [7:0]       walk_asid;
  logic             fill_valid = 1'b0;
  logic             fill_fault = 1'b0;
  logic [19:0]      fill_vpn = '0;
  logic [7:0]       fill_asid = '0;
  logic [19:0]      fill_ppn = '0;
  logic [2:0]       fill_perm = '0;
  logic             fill_dirty = 1'b0;
  logic             req_fault;
  logic             flush_all = 1'b0;
  logic             flush_asid_en = 1'b0;
  logic [7:0]       flush_asid = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tlb_fa_asid #(.ENTRIES(ENTRIES)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk);
    asid_we = 1'b1; asid_wdata = a;
    @(negedge clk);
    asid_we = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                      input logic [2:0] perm, input logic dirty);
    @(negedge clk);
    fill_valid = 1'b1; fill_fault = 1'b0; fill_vpn = vpn; fill_asid = asid;
    fill_ppn = ppn; fill_perm = perm; fill_dirty = dirty;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look_hit(input string req, input logic [19:0] vpn, input int slot,
                          input logic [19:0] ppn, input logic [2:0] perm, input logic dirty);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn;
    #1;
    chk({req, " hit"}, 32'(lk_hit), 32'd1);
    chk({req, " slot"}, 32'(lk_slot), 32'(slot));
    chk({req, " ppn"}, 32'(lk_ppn), 32'(ppn));
    chk({req, " perm"}, 32'(lk_perm), 32'(perm));
    chk({req, " dirty"}, 32'(lk_dirty), 32'(dirty));
    lk_valid = 1'b0;
  endtask

  task automatic look_miss(input string req, input logic [19:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn;
    #1;
    chk({req, " miss"}, 32'(lk_hit), 32'd0);
    chk("R4 walk_req", 32'(walk_req), 32'd1);
    chk("R4 walk_vpn", 32'(walk_vpn), 32'(vpn));
    chk("R4 walk_asid", 32'(walk_asid), 32'(asid));
    lk_valid = 1'b0;
  endtask

  task automatic t_reset;
    look_miss("R1 after reset", 20'h00000, 8'd0);
    look_miss("R1 after reset", 20'h12345, 8'd0);
  endtask

  task automatic t_fill_lowest;
    set_asid(8'd1);
    for (int i = 0; i < ENTRIES; i++)
      fill(20'h100 + 20'(i), 8'd1, 20'h800 + 20'(i), 3'(i % 8), 1'(i % 2));
    for (int i = 0; i < ENTRIES; i++)
      look_hit("R2 R6 fill order", 20'h100 + 20'(i), i, 20'h800 + 20'(i), 3'(i % 8), 1'(i % 2));
  endtask

  task automatic t_fault;
    @(negedge clk);
    fill_valid = 1'b1; fill_fault = 1'b1; fill_vpn = 20'h300; fill_asid = 8'd1;
    #1;
    chk("R5 req_fault", 32'(req_fault), 32'd1);
    @(negedge clk);
    fill_valid = 1'b0; fill_fault = 1'b0;
    #1;
    chk("R5 req_fault drop", 32'(req_fault), 32'd0);
    look_miss("R5 fault not stored", 20'h300, 8'd1);
    look_hit("R5 no eviction", 20'h100, 0, 20'h800, 3'd0, 1'b0);
  endtask

  task automatic t_asid_switch;
    @(negedge clk);
    asid_we = 1'b1; asid_wdata = 8'd2; lk_valid = 1'b1; lk_vpn = 20'h105;
    #1;
    chk("R12 old asid same cycle", 32'(lk_hit), 32'd1);
    @(negedge clk);
    asid_we = 1'b0;
    #1;
    chk("R3 R12 other asid misses", 32'(lk_hit), 32'd0);
    chk("R4 walk_asid new", 32'(walk_asid), 32'd2);
    lk_valid = 1'b0;
  endtask

  task automatic t_round_robin;
    fill(20'h105, 8'd2, 20'hA05, 3'd6, 1'b1);
    look_hit("R3 R7 asid2 in slot0", 20'h105, 0, 20'hA05, 3'd6, 1'b1);
    set_asid(8'd1);
    look_hit("R3 asid1 coexists", 20'h105, 5, 20'h805, 3'd5, 1'b1);
    look_miss("R7 slot0 evicted", 20'h100, 8'd1);
    fill(20'h400, 8'd1, 20'hC00, 3'd4, 1'b0);
    look_hit("R7 next victim", 20'h400, 1, 20'hC00, 3'd4, 1'b0);
  endtask

  task automatic t_duplicate;
    fill(20'h103, 8'd1, 20'hABC, 3'd7, 1'b1);
    look_hit("R8 overwrite in place", 20'h103, 3, 20'hABC, 3'd7, 1'b1);
    fill(20'h401, 8'd1, 20'hC01, 3'd2, 1'b0);
    look_hit("R8 pointer unchanged", 20'h401, 2, 20'hC01, 3'd2, 1'b0);
  endtask

  task automatic t_wrap;
    for (int k = 0; k < ENTRIES - 3; k++)
      fill(20'h500 + 20'(k), 8'd1, 20'hD00 + 20'(k), 3'd1, 1'b0);
    look_hit("R7 last slot", 20'h500 + 20'(ENTRIES - 4), ENTRIES - 1, 20'hD00 + 20'(ENTRIES - 4), 3'd1, 1'b0);
    fill(20'h600, 8'd1, 20'hE00, 3'd3, 1'b1);
    look_hit("R7 wrap to slot0", 20'h600, 0, 20'hE00, 3'd3, 1'b1);
  endtask

  task automatic t_flush_by_asid;
    fill(20'h700, 8'd2, 20'hF00, 3'd4, 1'b0);
    fill(20'h701, 8'd2, 20'hF01, 3'd4, 1'b0);
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = 8'd2;
    @(negedge clk);
    flush_asid_en = 1'b0;
    set_asid(8'd2);
    look_miss("R10 asid2 flushed", 20'h700, 8'd2);
    look_miss("R10 asid2 flushed", 20'h701, 8'd2);
    set_asid(8'd1);
    look_hit("R10 asid1 kept", 20'h600, 0, 20'hE00, 3'd3, 1'b1);
    fill(20'h702, 8'd1, 20'hF02, 3'd5, 1'b0);
    look_hit("R6 lowest free slot", 20'h702, 1, 20'hF02, 3'd5, 1'b0);
  endtask

  task automatic t_flush_vs_fill;
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = 8'd9;
    fill_valid = 1'b1; fill_vpn = 20'h800; fill_asid = 8'd1; fill_ppn = 20'h111;
    @(negedge clk);
    flush_asid_en = 1'b0; fill_valid = 1'b0;
    look_miss("R11 fill dropped", 20'h800, 8'd1);
  endtask

  task automatic t_flush_all;
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    look_miss("R9 flushed", 20'h600, 8'd1);
    look_miss("R9 flushed", 20'h702, 8'd1);
    fill(20'h900, 8'd1, 20'h999, 3'd7, 1'b0);
    look_hit("R6 R9 slot0 after flush", 20'h900, 0, 20'h999, 3'd7, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_lowest();
    t_fault();
    t_asid_switch();
    t_round_robin();
    t_duplicate();
    t_wrap();
    t_flush_by_asid();
    t_flush_vs_fill();
    t_flush_all();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule